// File: doc/BRIEF.md
# Configurable Two-Channel Serial Audio Transmitter

This block accepts pairs of parallel audio samples (one left word, one right word) on a valid/ready stream and serialises them MSB first onto a single data line. A bit clock and a frame clock go with the data line. The frame clock marks which channel is being sent. In master mode the block makes both clocks from its own clock: the bit clock runs at half the block clock, and a frame lasts 64 or 128 bit periods. In slave mode it follows a bit clock and a frame clock that arrive from outside. It passes them through a two-flop synchronizer and detects their edges.

Run-time configuration pins set the output word length, the justification and the one-bit MSB delay. They also set the bit-clock edge on which the data changes and which channel a high frame clock stands for. A sample pair is taken once per frame, when the left half begins. The stream takes no pair at any other time. If no pair is offered at that moment, the whole frame carries zeros.

Back-pressure rules: `s_ready_o` is high for exactly one block-clock cycle per frame. A pair moves when `s_valid_i` and `s_ready_o` are both high at a rising edge of `clk_i`. While `s_valid_i` is high and no transfer has happened, the source must hold the pair steady. A pair that is offered while `s_ready_o` is low waits for the next frame.

Top module: `audio_serial_tx`

## Requirements
- R1: In master mode (`cfg_master_i`=1) `bclk_o` inverts on every `clk_i` cycle. When `cfg_bclk_inv_i`=0 the data and frame clock change only where `bclk_o` falls, and a receiver samples on the rising edge. When `cfg_bclk_inv_i`=1 both roles swap. `sdata_o` never changes while `bclk_o` moves to the sampling level.
- R2: In master mode a frame lasts 64 bit periods (`cfg_ratio128_i`=0) or 128 bit periods (=1). The first half carries the left channel. `fclk_o` is high for the left half when `cfg_frame_pol_i`=0 and low for it when `cfg_frame_pol_i`=1. It changes only on the edge where the data changes.
- R3: `cfg_res_i` sets the output word length: 00 gives 24 bits, 01 gives 20 bits, 10 gives 16 bits, and the unsupported code 11 gives 24 bits. Bits go out MSB first, and the low-order bits that do not fit are dropped.
- R4: With left justification (`cfg_rjust_i`=0) the MSB sits in the first bit period of the half when `cfg_delay_i`=0, and in the second when `cfg_delay_i`=1.
- R5: With right justification (`cfg_rjust_i`=1) the LSB sits in the last bit period of the half, and `cfg_delay_i` has no effect.
- R6: Every bit period outside the data word is driven low.
- R7: `s_ready_o` pulses for one `clk_i` cycle right before each left half begins. The pair accepted then is sent in that frame. If `s_valid_i` is low at that edge, the frame sends zeros on both channels.
- R8: In slave mode `bclk_o`, `fclk_o` and `clk_oe_o` are low. Data follows `ext_bclk_i` and `ext_fclk_i`, which pass through a two-flop synchronizer, with the same edge and polarity rules as master mode. Each half is counted from the frame-clock change, and `cfg_ratio128_i` sets the half length that right justification uses.
- R9: While `rst_ni` is low, `sdata_o` and `s_ready_o` are low and the held sample pair is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block (master) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_master_i | input | 1 | 1: generate clocks, 0: follow external clocks |
| cfg_ratio128_i | input | 1 | 0: 64, 1: 128 bit periods per frame |
| cfg_res_i | input | 2 | Word length code (00 24, 01 20, 10 16, 11 24) |
| cfg_rjust_i | input | 1 | 1: right justified |
| cfg_delay_i | input | 1 | 1: MSB one bit period late (left justified only) |
| cfg_bclk_inv_i | input | 1 | Swaps the bit-clock edge roles |
| cfg_frame_pol_i | input | 1 | 0: high frame clock is left, 1: high is right |
| s_valid_i | input | 1 | Sample pair offered |
| s_ready_o | output | 1 | Pair taken at this edge if valid |
| s_left_i | input | SAMPLE_W | Left sample |
| s_right_i | input | SAMPLE_W | Right sample |
| ext_bclk_i | input | 1 | External bit clock (slave) |
| ext_fclk_i | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| fclk_o | output | 1 | Generated frame clock (master) |
| clk_oe_o | output | 1 | High when the clock outputs are driven |
| sdata_o | output | 1 | Serial data |

## Verification
The hardest case to reach is the frame boundary in slave mode. There the pair is taken on a synchronised external edge, three block clocks after the external edge itself, and right-justified placement relies on the configured half length, not on a counted one. The bench drives a slow external bit clock and frame clock with both polarity settings. Its model delays them through its own history of sampled values. Other runs drop `s_valid_i` at random, so that some frame starts find no pair and must send zeros.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    RES_FULL = 2'b00,
    RES_MID  = 2'b01,
    RES_LOW  = 2'b10,
    RES_RSV  = 2'b11
  } res_code_e;

  // Output word length for a resolution code; the reserved code maps to full width.
  function automatic int res_width(input logic [1:0] code, input int full);
    case (code)
      RES_MID: return full - 4;
      RES_LOW: return full - 8;
      default: return full;
    endcase
  endfunction

endpackage

// File: rtl/audio_tx_timing.sv
module audio_tx_timing #(
  parameter int POS_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             ratio128_i,
  input  logic             bclk_inv_i,
  input  logic             frame_pol_i,
  input  logic             ext_bclk_i,
  input  logic             ext_fclk_i,
  output logic             phase_o,
  output logic [POS_W-1:0] pos_o,
  output logic             right_o,
  output logic             start_o
);
  localparam int HALF_MAX = 1 << (POS_W - 1);
  localparam int HALF_MIN = HALF_MAX / 2;

  logic [SYNC_STAGES:0] bsh_q, fsh_q;
  logic                 h_q;
  logic [POS_W-1:0]     pos_q, nxt_pos, last_pos;
  logic                 right_q, nxt_right;
  logic                 adv_m, adv_s, adv;
  logic                 nb_new, nb_old, side_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsh_q <= '0;
      fsh_q <= '0;
    end else begin
      bsh_q <= {bsh_q[SYNC_STAGES-1:0], ext_bclk_i};
      fsh_q <= {fsh_q[SYNC_STAGES-1:0], ext_fclk_i};
    end
  end

  assign last_pos = ratio128_i ? POS_W'(HALF_MAX - 1) : POS_W'(HALF_MIN - 1);
  assign adv_m    = master_i & h_q;
  assign nb_new   = bsh_q[SYNC_STAGES-1] ^ bclk_inv_i;
  assign nb_old   = bsh_q[SYNC_STAGES] ^ bclk_inv_i;
  assign adv_s    = ~master_i & nb_old & ~nb_new;
  assign side_s   = ~(fsh_q[SYNC_STAGES-1] ^ frame_pol_i);
  assign adv      = adv_m | adv_s;

  always_comb begin
    nxt_pos   = pos_q;
    nxt_right = right_q;
    if (master_i) begin
      if (pos_q >= last_pos) begin
        nxt_pos   = '0;
        nxt_right = ~right_q;
      end else begin
        nxt_pos = pos_q + 1'b1;
      end
    end else if (side_s != right_q) begin
      nxt_pos   = '0;
      nxt_right = side_s;
    end else if (pos_q != '1) begin
      nxt_pos = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q     <= 1'b0;
      pos_q   <= '0;
      right_q <= 1'b0;
    end else begin
      h_q <= master_i ? ~h_q : 1'b0;
      if (adv) begin
        pos_q   <= nxt_pos;
        right_q <= nxt_right;
      end
    end
  end

  assign phase_o = h_q;
  assign pos_o   = pos_q;
  assign right_o = right_q;
  assign start_o = adv & right_q & ~nxt_right;
endmodule

// File: rtl/audio_tx_hold.sv
module audio_tx_hold #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam int NCH = 2;

  logic [SAMPLE_W-1:0] in_w [NCH];
  assign in_w[0] = left_i;
  assign in_w[1] = right_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q <= '0;
      else if (take_i) word_q <= valid_i ? in_w[c] : '0;
    end
  end

  assign left_o  = g_ch[0].word_q;
  assign right_o = g_ch[1].word_q;
endmodule

// File: rtl/audio_tx_bitsel.sv
module audio_tx_bitsel
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int POS_W    = 7
) (
  input  logic [POS_W-1:0]    pos_i,
  input  logic                right_i,
  input  logic [1:0]          res_i,
  input  logic                rjust_i,
  input  logic                delay_i,
  input  logic                ratio128_i,
  input  logic [SAMPLE_W-1:0] left_word_i,
  input  logic [SAMPLE_W-1:0] right_word_i,
  output logic                bit_o
);
  localparam int HALF_MAX = 1 << (POS_W - 1);
  localparam int IDX_W    = $clog2(SAMPLE_W);

  always_comb begin
    int nb;
    int hw;
    int first;
    int p;
    logic [SAMPLE_W-1:0] word;
    nb    = res_width(res_i, SAMPLE_W);
    hw    = ratio128_i ? HALF_MAX : HALF_MAX / 2;
    first = rjust_i ? (hw - nb) : (delay_i ? 1 : 0);
    p     = int'(pos_i);
    word  = right_i ? right_word_i : left_word_i;
    bit_o = 1'b0;
    if (p >= first && p < first + nb)
      bit_o = word[IDX_W'(SAMPLE_W - 1 - (p - first))];
  end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
  parameter int SAMPLE_W    = 24,
  parameter int POS_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_master_i,
  input  logic                cfg_ratio128_i,
  input  logic [1:0]          cfg_res_i,
  input  logic                cfg_rjust_i,
  input  logic                cfg_delay_i,
  input  logic                cfg_bclk_inv_i,
  input  logic                cfg_frame_pol_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [SAMPLE_W-1:0] s_left_i,
  input  logic [SAMPLE_W-1:0] s_right_i,
  input  logic                ext_bclk_i,
  input  logic                ext_fclk_i,
  output logic                bclk_o,
  output logic                fclk_o,
  output logic                clk_oe_o,
  output logic                sdata_o
);
  logic                phase;
  logic [POS_W-1:0]    pos;
  logic                right_side;
  logic                frame_start;
  logic [SAMPLE_W-1:0] left_word, right_word;

  audio_tx_timing #(.POS_W(POS_W), .SYNC_STAGES(SYNC_STAGES)) u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_i    (cfg_master_i),
    .ratio128_i  (cfg_ratio128_i),
    .bclk_inv_i  (cfg_bclk_inv_i),
    .frame_pol_i (cfg_frame_pol_i),
    .ext_bclk_i  (ext_bclk_i),
    .ext_fclk_i  (ext_fclk_i),
    .phase_o     (phase),
    .pos_o       (pos),
    .right_o     (right_side),
    .start_o     (frame_start)
  );

  audio_tx_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (frame_start),
    .valid_i (s_valid_i),
    .left_i  (s_left_i),
    .right_i (s_right_i),
    .left_o  (left_word),
    .right_o (right_word)
  );

  audio_tx_bitsel #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_bitsel (
    .pos_i        (pos),
    .right_i      (right_side),
    .res_i        (cfg_res_i),
    .rjust_i      (cfg_rjust_i),
    .delay_i      (cfg_delay_i),
    .ratio128_i   (cfg_ratio128_i),
    .left_word_i  (left_word),
    .right_word_i (right_word),
    .bit_o        (sdata_o)
  );

  assign s_ready_o = frame_start;
  assign clk_oe_o  = cfg_master_i;
  assign bclk_o    = cfg_master_i & (phase ^ cfg_bclk_inv_i);
  assign fclk_o    = cfg_master_i & (~right_side ^ cfg_frame_pol_i);
endmodule

// File: rtl/audio_serial_tx_chk.sv
module audio_serial_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_master_i,
  input logic       cfg_ratio128_i,
  input logic [1:0] cfg_res_i,
  input logic       cfg_rjust_i,
  input logic       cfg_delay_i,
  input logic       cfg_bclk_inv_i,
  input logic       cfg_frame_pol_i,
  input logic       s_ready_o,
  input logic       bclk_o,
  input logic       fclk_o,
  input logic       sdata_o
);
  logic       armed_q;
  logic [7:0] cfg_w;
  logic       samp_lvl;

  assign cfg_w    = {cfg_master_i, cfg_ratio128_i, cfg_res_i, cfg_rjust_i,
                     cfg_delay_i, cfg_bclk_inv_i, cfg_frame_pol_i};
  assign samp_lvl = bclk_o ^ cfg_bclk_inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R1
  bclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cfg_master_i && $stable(cfg_w)) |-> (bclk_o != $past(bclk_o)));

  // R1
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cfg_master_i && $stable(cfg_w) && samp_lvl && !$past(samp_lvl))
      |-> $stable(sdata_o));

  // R2
  fclk_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cfg_master_i && $stable(cfg_w) && (fclk_o != $past(fclk_o)))
      |-> !samp_lvl);

  // R7
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |=> !s_ready_o);

  // R7
  ready_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ready_o && cfg_master_i) |=>
      (!$stable(cfg_w) || (fclk_o == ~cfg_frame_pol_i)));
endmodule

bind audio_serial_tx audio_serial_tx_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_master_i    (cfg_master_i),
  .cfg_ratio128_i  (cfg_ratio128_i),
  .cfg_res_i       (cfg_res_i),
  .cfg_rjust_i     (cfg_rjust_i),
  .cfg_delay_i     (cfg_delay_i),
  .cfg_bclk_inv_i  (cfg_bclk_inv_i),
  .cfg_frame_pol_i (cfg_frame_pol_i),
  .s_ready_o       (s_ready_o),
  .bclk_o          (bclk_o),
  .fclk_o          (fclk_o),
  .sdata_o         (sdata_o)
);

// File: tb/audio_serial_tx_bench.sv
module audio_serial_tx_bench;
  localparam int SW = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic c_master = 1'b0, c_ratio = 1'b0, c_rjust = 1'b0, c_delay = 1'b0;
  logic c_inv = 1'b0, c_pol = 1'b0;
  logic [1:0] c_res = 2'b00;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [SW-1:0] s_left = '0, s_right = '0;
  logic ext_b = 1'b0, ext_f = 1'b0;
  logic bclk, fclk, oe, sdata;

  int n_cmp = 0, n_bad = 0;
  int vprob = 100;
  string cur_tag = "R3";

  audio_serial_tx u_audio_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_master_i(c_master), .cfg_ratio128_i(c_ratio),
    .cfg_res_i(c_res), .cfg_rjust_i(c_rjust), .cfg_delay_i(c_delay),
    .cfg_bclk_inv_i(c_inv), .cfg_frame_pol_i(c_pol), .s_valid_i(s_valid),
    .s_ready_o(s_ready), .s_left_i(s_left), .s_right_i(s_right),
    .ext_bclk_i(ext_b), .ext_fclk_i(ext_f), .bclk_o(bclk), .fclk_o(fclk),
    .clk_oe_o(oe), .sdata_o(sdata)
  );

  // ---------------- behavioural reference model ----------------
  bit m_h = 0;
  int m_fs = 0, s_pos = 0;
  bit s_side = 0, took = 0;
  logic [SW-1:0] m_l = '0, m_r = '0;
  bit hb [4];
  bit hf [4];
  int e_div = 0, e_bits = 0;
  bit e_r = 0, e_right = 0;

  function automatic int nbits();
    if (c_res == 2'b01) return 20;
    if (c_res == 2'b10) return 16;
    return 24;
  endfunction
  function automatic int halfw();
    return c_ratio ? 64 : 32;
  endfunction
  function automatic bit slave_adv();
    return ((hb[2] ^ c_inv) == 1'b1) && ((hb[1] ^ c_inv) == 1'b0);
  endfunction
  function automatic bit slave_side();
    return !(hf[1] ^ c_pol);
  endfunction
  function automatic bit exp_bit(input bit side, input int pos);
    int first;
    logic [SW-1:0] w;
    first = c_rjust ? halfw() - nbits() : (c_delay ? 1 : 0);
    w = side ? m_r : m_l;
    if (pos >= first && pos < first + nbits()) return w[SW-1-(pos-first)];
    return 1'b0;
  endfunction

  task automatic load_pair();
    took = s_valid;
    m_l = s_valid ? s_left : '0;
    m_r = s_valid ? s_right : '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_fs = 0; s_pos = 0; s_side = 0; took = 0; m_l = '0; m_r = '0;
      for (int i = 0; i < 4; i++) begin hb[i] = 0; hf[i] = 0; end
    end else begin
      took = 0;
      if (c_master) begin
        if (m_h) begin
          if (m_fs == 2 * halfw() - 1) begin load_pair(); m_fs = 0; end
          else m_fs++;
        end
        m_h = !m_h;
      end else begin
        m_h = 0;
        if (slave_adv()) begin
          bit ns;
          ns = slave_side();
          if (ns != s_side) s_pos = 0;
          else if (s_pos < 127) s_pos++;
          if (s_side && !ns) load_pair();
          s_side = ns;
        end
      end
      for (int i = 3; i > 0; i--) begin hb[i] = hb[i-1]; hf[i] = hf[i-1]; end
      hb[0] = ext_b;
      hf[0] = ext_f;
    end
  end

  task automatic check1(input logic act, input logic exp, input string what, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, then drive stimulus
  always @(negedge clk) begin
    bit side, eb, ef, er;
    int pos;
    if (c_master) begin
      side = (m_fs >= halfw());
      pos  = m_fs % halfw();
      eb   = m_h ^ c_inv;
      ef   = (!side) ^ c_pol;
      er   = rst_n && m_h && (m_fs == 2 * halfw() - 1);
    end else begin
      side = s_side;
      pos  = s_pos;
      eb   = 0;
      ef   = 0;
      er   = rst_n && slave_adv() && s_side && !slave_side();
    end
    check1(bclk, eb, "bclk", c_master ? "R1" : "R8");
    check1(fclk, ef, "fclk", "R2");
    check1(oe, c_master, "clk_oe", "R8");
    check1(s_ready, er, "ready", "R7");
    check1(sdata, exp_bit(side, pos), "sdata", cur_tag);

    // stream source obeying valid/ready
    if (took || !s_valid) begin
      s_valid = (($urandom % 100) < vprob);
      s_left  = SW'($urandom);
      s_right = SW'($urandom);
    end
    // external clock pair for slave runs: 8 block clocks per bit
    e_div++;
    if (e_div == 4) begin
      e_div = 0;
      e_r = !e_r;
      if (!e_r) begin
        e_bits++;
        if (e_bits == halfw()) begin e_bits = 0; e_right = !e_right; end
      end
    end
    ext_b = e_r ^ c_inv;
    ext_f = (!e_right) ^ c_pol;
  end

  task automatic run_case(input bit ms, input bit rt, input logic [1:0] rs, input bit rj,
                          input bit dl, input bit iv, input bit pl, input int vp,
                          input int cyc, input string tag);
    @(posedge clk); #1;
    rst_n = 0;
    c_master = ms; c_ratio = rt; c_res = rs; c_rjust = rj; c_delay = dl;
    c_inv = iv; c_pol = pl; vprob = vp; cur_tag = tag;
    e_div = 0; e_bits = 0; e_r = 0; e_right = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R9: reset state
    check1(sdata, 1'b0, "reset sdata", "R9");
    check1(s_ready, 1'b0, "reset ready", "R9");
    @(posedge clk); #1;
    rst_n = 1;
    repeat (cyc) @(posedge clk);
  endtask

  initial begin
    // R3 R4: 24-bit, left justified, 64 periods
    run_case(1, 0, 2'b00, 0, 0, 0, 0, 100, 1500, "R3 R4");
    // R3 R5: 20-bit right justified, 128 periods, inverted clock and frame polarity
    run_case(1, 1, 2'b01, 1, 0, 1, 1, 100, 2000, "R3 R5");
    // R4 R6: 16-bit left justified with one-bit delay
    run_case(1, 0, 2'b10, 0, 1, 0, 0, 100, 1500, "R4 R6");
    // R3 R5: code 11 gives 24 bits, delay ignored when right justified
    run_case(1, 0, 2'b11, 1, 1, 0, 1, 100, 1500, "R3 R5");
    // R7: random valid drops, frames without a pair send zeros
    run_case(1, 1, 2'b00, 0, 0, 1, 0, 40, 3000, "R7");
    // R8: slave, 24-bit left justified delayed, inverted clock
    run_case(0, 0, 2'b00, 0, 1, 1, 0, 100, 3000, "R8");
    // R8 R6: slave, 16-bit right justified over 64-period halves
    run_case(0, 1, 2'b10, 1, 0, 0, 1, 70, 3500, "R8 R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule